// File: doc/BRIEF.md
# Priority Channel Mapper and Host Interrupt Router

This block sits after the interrupt source capture stage. It takes one pending bit per source and sends the interrupt on to two host lines: a fast line and a normal line. Software gives each source a priority channel from 0 to 31. A lower channel number means higher priority. Software also gives each channel a host line. In every cycle the block picks one winner for each host. The winner is the pending source on the best channel routed to that host. If several pending sources share that channel, the lowest-numbered one wins.

A global enable and one enable per host control the host lines. The per-host enables are changed by writing a host number to a set register or to a clear register. A readback register for each host gives the number of the winning source, so an interrupt handler can tell which source to serve. Configuration goes through a simple synchronous register port. Writes take effect on the clock edge, and reads are combinational from the word address.

Top module: `prio_router`

## Requirements
- R1: After reset, both host lines are low. The global enable (address 0, bit 0) reads 0. The host enable status (address 3, bit h for host h) reads 0. Every channel-map register reads 0. The host-map registers read their default values: 0x01010000 for channels 0 to 3, and 0x01010101 for every other group of four channels.
- R2: The channel of source s is held in channel-map register s/4, at word address 16 + s/4, in byte s%4, with byte 0 at bits 7:0. The channel number is bits 4:0 of that byte. The upper three bits of the byte are stored and read back, but they do not affect routing.
- R3: Among the pending sources routed to one host, the source on the lowest-numbered channel wins.
- R4: When several pending sources on the winning channel are routed to the same host, the lowest-numbered source wins.
- R5: Channel c is routed to a host by bit 0 of byte c%4 in host-map register c/4, at word address 32 + c/4. A value of 0 selects the fast host (host 0, `irq_o[0]`). A value of 1 selects the normal host (host 1, `irq_o[1]`). By default, channels 0 and 1 go to the fast host and channels 2 to 31 go to the normal host.
- R6: While the global enable is 0, both host lines stay low.
- R7: Writing a host number to address 1 sets that host's enable. Writing a host number to address 2 clears it. A host number of 2 or more leaves every enable unchanged. A host line is asserted only while its enable is 1.
- R8: The winner register for host h is at address 4 + h. It holds the winning source number in its low bits and has bit 31 clear. When no source routed to that host is pending, it reads 0x80000000. This register does not depend on the global or host enables.
- R9: The host lines and the winner registers are registered. A change in the pending vector shows at the outputs one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_SRC | Pending bit per source from the capture stage |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | NUM_HOST | Host lines: bit 0 is the fast host, bit 1 is the normal host |

## Verification
The hardest situation to reach is a tie on the winning channel while a better channel is pending for the other host. This is where the channel comparison and the source-order tie-break can be confused. To reach it, the stimulus first writes a set of channel-map values: two sources share one channel, one source sits on a worse channel, and one source stays on channel 0. It then drives pending patterns that remove each source in turn from that mix. A host-map rewrite then moves one shared channel to the fast host. This shows that routing follows the channel and not the source.

// File: rtl/prio_route_pkg.sv
package prio_route_pkg;

    localparam int CHANNELS = 32;
    localparam int CH_W     = 5;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int HMAP_REGS = CHANNELS / 4;

    localparam logic [ADDR_W-1:0] A_GLOBAL    = 6'd0;
    localparam logic [ADDR_W-1:0] A_HEN_SET   = 6'd1;
    localparam logic [ADDR_W-1:0] A_HEN_CLR   = 6'd2;
    localparam logic [ADDR_W-1:0] A_HEN_STAT  = 6'd3;
    localparam int                A_WIN_BASE  = 4;
    localparam int                A_CMAP_BASE = 16;
    localparam int                A_HMAP_BASE = 32;

    // per-host pick result
    typedef struct packed {
        logic       valid;
        logic [7:0] src;
    } pick_t;

    // channels 0..1 -> fast host (0), remaining -> normal host (1)
    function automatic logic [DATA_W-1:0] hmap_default(input int reg_idx);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int b = 0; b < 4; b++) begin
            w[8*b] = ((reg_idx * 4 + b) >= 2);
        end
        return w;
    endfunction

endpackage

// File: rtl/prio_cfg_regs.sv
module prio_cfg_regs
    import prio_route_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_HOST = 2,
    localparam int NMAP    = (NUM_SRC + 3) / 4,
    localparam int HOST_W  = (NUM_HOST > 1) ? $clog2(NUM_HOST) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               reg_we,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [DATA_W-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                  reg_rdata,
    input  logic [NUM_HOST-1:0][DATA_W-1:0]    win_idx,
    output logic                               global_en,
    output logic [NUM_HOST-1:0]                host_en,
    output logic [NUM_SRC-1:0][CH_W-1:0]       src_chan,
    output logic [CHANNELS-1:0][HOST_W-1:0]    chan_host
);

    logic [NMAP-1:0][DATA_W-1:0]      cmap_q;
    logic [HMAP_REGS-1:0][DATA_W-1:0] hmap_q;
    logic                             host_ok;

    assign host_ok = (reg_wdata < DATA_W'(NUM_HOST));

    always_ff @(posedge clk) begin
        if (rst) begin
            global_en <= 1'b0;
            host_en   <= '0;
            for (int i = 0; i < NMAP; i++)      cmap_q[i] <= '0;
            for (int i = 0; i < HMAP_REGS; i++) hmap_q[i] <= hmap_default(i);
        end else if (reg_we) begin
            if (reg_addr == A_GLOBAL)              global_en <= reg_wdata[0];
            if (reg_addr == A_HEN_SET && host_ok)  host_en[reg_wdata[HOST_W-1:0]] <= 1'b1;
            if (reg_addr == A_HEN_CLR && host_ok)  host_en[reg_wdata[HOST_W-1:0]] <= 1'b0;
            for (int i = 0; i < NMAP; i++)
                if (reg_addr == ADDR_W'(A_CMAP_BASE + i)) cmap_q[i] <= reg_wdata;
            for (int i = 0; i < HMAP_REGS; i++)
                if (reg_addr == ADDR_W'(A_HMAP_BASE + i)) hmap_q[i] <= reg_wdata;
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_field
        assign src_chan[s] = cmap_q[s/4][8*(s%4) +: CH_W];
    end

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan_field
        assign chan_host[c] = hmap_q[c/4][8*(c%4) +: HOST_W];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_GLOBAL)   reg_rdata[0] = global_en;
        if (reg_addr == A_HEN_STAT) reg_rdata[NUM_HOST-1:0] = host_en;
        for (int h = 0; h < NUM_HOST; h++)
            if (reg_addr == ADDR_W'(A_WIN_BASE + h)) reg_rdata = win_idx[h];
        for (int i = 0; i < NMAP; i++)
            if (reg_addr == ADDR_W'(A_CMAP_BASE + i)) reg_rdata = cmap_q[i];
        for (int i = 0; i < HMAP_REGS; i++)
            if (reg_addr == ADDR_W'(A_HMAP_BASE + i)) reg_rdata = hmap_q[i];
    end

endmodule

// File: rtl/prio_host_pick.sv
module prio_host_pick
    import prio_route_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_HOST = 2,
    parameter int HOST_ID  = 0,
    localparam int HOST_W  = (NUM_HOST > 1) ? $clog2(NUM_HOST) : 1
) (
    input  logic [NUM_SRC-1:0]              pend,
    input  logic [NUM_SRC-1:0][CH_W-1:0]    src_chan,
    input  logic [CHANNELS-1:0][HOST_W-1:0] chan_host,
    output pick_t                           pick
);

    logic [CH_W-1:0] best_ch;

    // ascending scan with strict compare: lowest channel, then lowest source
    always_comb begin
        pick    = '0;
        best_ch = '1;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (pend[s] && chan_host[src_chan[s]] == HOST_W'(HOST_ID) &&
                (!pick.valid || src_chan[s] < best_ch)) begin
                pick.valid = 1'b1;
                pick.src   = 8'(s);
                best_ch    = src_chan[s];
            end
        end
    end

endmodule

// File: rtl/prio_router.sv
module prio_router
    import prio_route_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_HOST = 2,
    localparam int HOST_W  = (NUM_HOST > 1) ? $clog2(NUM_HOST) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  pend_i,
    input  logic                reg_we,
    input  logic [5:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_HOST-1:0] irq_o
);

    logic                            global_en;
    logic [NUM_HOST-1:0]             host_en;
    logic [NUM_SRC-1:0][CH_W-1:0]    src_chan;
    logic [CHANNELS-1:0][HOST_W-1:0] chan_host;
    logic [NUM_HOST-1:0][DATA_W-1:0] win_q;
    pick_t                           pick [NUM_HOST];

    prio_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_HOST(NUM_HOST)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .win_idx   (win_q),
        .global_en (global_en),
        .host_en   (host_en),
        .src_chan  (src_chan),
        .chan_host (chan_host)
    );

    for (genvar h = 0; h < NUM_HOST; h++) begin : g_host
        prio_host_pick #(.NUM_SRC(NUM_SRC), .NUM_HOST(NUM_HOST), .HOST_ID(h)) u_pick (
            .pend      (pend_i),
            .src_chan  (src_chan),
            .chan_host (chan_host),
            .pick      (pick[h])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                irq_o[h] <= 1'b0;
                win_q[h] <= 32'h8000_0000;
            end else begin
                irq_o[h] <= global_en & host_en[h] & pick[h].valid;
                win_q[h] <= {~pick[h].valid, 23'd0, pick[h].src};
            end
        end
    end

endmodule

// File: rtl/prio_router_chk.sv
module prio_router_chk
    import prio_route_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_HOST = 2
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_SRC-1:0]              pend_i,
    input logic                            reg_we,
    input logic [5:0]                      reg_addr,
    input logic [31:0]                     reg_wdata,
    input logic [NUM_HOST-1:0]             irq_o,
    input logic                            global_en,
    input logic [NUM_HOST-1:0]             host_en,
    input logic [NUM_HOST-1:0][DATA_W-1:0] win_q
);

    p_global_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !global_en |=> (irq_o == '0));

    p_hen_set_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_HEN_SET && reg_wdata == 32'd0) |=> host_en[0]);

    p_hen_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_HEN_CLR && reg_wdata == 32'd0) |=> !host_en[0]);

    for (genvar h = 0; h < NUM_HOST; h++) begin : g_chk
        p_host_gate_r7: assert property (@(posedge clk) disable iff (rst)
            !host_en[h] |=> !irq_o[h]);

        p_needs_pending_r9: assert property (@(posedge clk) disable iff (rst)
            irq_o[h] |-> $past(|pend_i));

        p_idle_flag_r8: assert property (@(posedge clk) disable iff (rst)
            (pend_i == '0) |=> (win_q[h] == 32'h8000_0000));
    end

endmodule

bind prio_router prio_router_chk #(.NUM_SRC(NUM_SRC), .NUM_HOST(NUM_HOST)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend_i),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .global_en (global_en),
    .host_en   (host_en),
    .win_q     (win_q)
);

// File: tb/tb_prio_router.sv
`timescale 1ns/1ps
module tb_prio_router;

    localparam int NSRC = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic [NSRC-1:0] pend_i;
    logic            reg_we;
    logic [5:0]      reg_addr;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic [1:0]      irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    prio_router #(.NUM_SRC(NSRC), .NUM_HOST(2)) dut (
        .clk(clk), .rst(rst), .pend_i(pend_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        check(req, reg_rdata, exp);
    endtask

    // drive pending at a falling edge, outputs sampled one rising edge later
    task automatic drive_pend(input logic [NSRC-1:0] p);
        @(negedge clk);
        pend_i = p;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 irq", 32'(irq_o), 32'h0);
        rd_chk("R1 global", 6'd0, 32'h0);
        rd_chk("R1 hen", 6'd3, 32'h0);
        rd_chk("R1 cmap0", 6'd16, 32'h0);
        rd_chk("R1 cmap3", 6'd19, 32'h0);
        rd_chk("R1 hmap0", 6'd32, 32'h0101_0000);
        rd_chk("R1 hmap7", 6'd39, 32'h0101_0101);
        rd_chk("R8 idle win0", 6'd4, 32'h8000_0000);
    endtask

    task automatic t_host_enable;
        wr(6'd1, 32'd0);
        wr(6'd1, 32'd1);
        wr(6'd1, 32'd2);
        rd_chk("R7 set both, 2 ignored", 6'd3, 32'h3);
        wr(6'd2, 32'd5);
        rd_chk("R7 clr 5 ignored", 6'd3, 32'h3);
        wr(6'd2, 32'd0);
        rd_chk("R7 clr host0", 6'd3, 32'h2);
        wr(6'd1, 32'd0);
        rd_chk("R7 set host0", 6'd3, 32'h3);
    endtask

    task automatic t_latency;
        wr(6'd0, 32'd1);
        rd_chk("R6 global on", 6'd0, 32'h1);
        @(negedge clk);
        pend_i = 16'h0008;
        #0.5;
        check("R9 not yet", 32'(irq_o), 32'h0);
        @(negedge clk);
        check("R9 fast after 1 cycle", 32'(irq_o), 32'h1);
        rd_chk("R8 win0 src3", 6'd4, 32'd3);
        rd_chk("R8 win1 idle", 6'd5, 32'h8000_0000);
        drive_pend('0);
        check("R9 drop", 32'(irq_o), 32'h0);
        rd_chk("R8 win0 idle again", 6'd4, 32'h8000_0000);
    endtask

    task automatic t_priority;
        wr(6'd16, 32'h0006_0900); // src1 ch9, src2 ch6
        wr(6'd17, 32'h0000_E600); // src5 byte 0xE6 -> ch6
        wr(6'd18, 32'h0000_1400); // src9 ch20
        rd_chk("R2 cmap0 readback", 6'd16, 32'h0006_0900);
        rd_chk("R2 upper bits kept", 6'd17, 32'h0000_E600);
        drive_pend(16'h0226);
        check("R3 normal irq", 32'(irq_o), 32'h2);
        rd_chk("R4 ch6 tie -> src2", 6'd5, 32'd2);
        drive_pend(16'h0220);
        rd_chk("R3 ch6 over ch20", 6'd5, 32'd5);
        drive_pend(16'h0202);
        rd_chk("R3 ch9 over ch20", 6'd5, 32'd1);
        drive_pend(16'h0200);
        rd_chk("R2 src9 alone", 6'd5, 32'd9);
        drive_pend(16'h0005);
        check("R5 both hosts", 32'(irq_o), 32'h3);
        rd_chk("R5 fast src0", 6'd4, 32'd0);
        rd_chk("R5 normal src2", 6'd5, 32'd2);
    endtask

    task automatic t_hostmap;
        wr(6'd33, 32'h0100_0101); // ch6 -> fast
        rd_chk("R5 hmap readback", 6'd33, 32'h0100_0101);
        drive_pend(16'h0004);
        check("R5 ch6 on fast", 32'(irq_o), 32'h1);
        rd_chk("R5 fast src2", 6'd4, 32'd2);
        rd_chk("R5 normal idle", 6'd5, 32'h8000_0000);
        wr(6'd33, 32'h0101_0101);
    endtask

    task automatic t_gating;
        drive_pend(16'h0005);
        check("R6 both on", 32'(irq_o), 32'h3);
        wr(6'd0, 32'd0);
        @(negedge clk);
        check("R6 global off", 32'(irq_o), 32'h0);
        rd_chk("R8 win ignores enable", 6'd4, 32'd0);
        wr(6'd0, 32'd1);
        wr(6'd2, 32'd1);
        @(negedge clk);
        check("R7 host1 off", 32'(irq_o), 32'h1);
        rd_chk("R8 win1 still valid", 6'd5, 32'd2);
        wr(6'd1, 32'd1);
        @(negedge clk);
        check("R7 host1 back", 32'(irq_o), 32'h3);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; pend_i = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_host_enable();
        t_latency();
        t_priority();
        t_hostmap();
        t_gating();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule